// File: doc/BRIEF.md
# Transport-Triggered Masked Bitstring Matcher

This functional unit sits on the move buses of a transport-triggered processor. It compares a data word against a stored reference pattern. The unit holds the pattern and a per-bit mask, and a compare starts as a side effect of a bus write into its trigger location. The match flag lands in a readable result location. A status word reports whether the unit is still evaluating or already holds a valid flag.

Several buses can move data in the same cycle, so the unit accepts one write per bus per cycle. Software can therefore load a new pattern and fire the trigger in the same instruction. Each instance decodes its own window of bus addresses, set by a base-address parameter. This lets several matchers coexist on the same buses.

Internally a three-state machine controls the compare:
- `ST_IDLE` means no result exists yet.
- `ST_EVAL` is the single compare cycle.
- `ST_HOLD` means a valid flag is held.

The machine moves between these states as follows:
- `fire`: any state goes to `ST_EVAL` on a trigger write.
- `finish`: `ST_EVAL` goes to `ST_HOLD` when no new trigger arrives.
- `restart`: `ST_EVAL` stays in `ST_EVAL` when a new trigger arrives during the compare.
- `keep`: `ST_IDLE` and `ST_HOLD` stay put otherwise.

Top module: `tt_match_unit`

## Requirements
- R1: Relative to `BASE_ADDR`, offset 0 is the pattern, 1 the mask, 2 the trigger word, 3 the result and 4 the status; all five read back. After reset the pattern reads 0, the mask all ones, the trigger word 0, the result 0 and the status 0.
- R2: A write to the pattern or the mask alone starts no compare, and leaves both the result and the status unchanged.
- R3: A trigger write sampled at clock edge E makes the status read 2 (busy, bit 1) in the cycle after E. From edge E+1 on, the status reads 1 (valid, bit 0) and the result of that compare is readable.
- R4: The compare matches when `((trigger ^ pattern) & mask) == 0`. Only bit positions whose mask bit is 1 take part, so an all-zero mask always matches.
- R5: The result reads 32'h1 on a match and 32'h0 on a mismatch.
- R6: Status bit 0 (valid) clears at the next trigger write, and bit 1 (busy) is set for the compare cycle.
- R7: When one bus writes the pattern and another writes the trigger in the same cycle, that compare uses the newly written pattern.
- R8: When several buses write the same location in the same cycle, the value from the highest-numbered bus is stored.
- R9: A read of an address outside the five locations returns 0. No read changes any state.
- R10: A trigger write that arrives during the compare cycle restarts the compare with the new word. Busy stays set for one more cycle, and the final result belongs to the later word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NUM_BUS | Per-bus write strobe |
| wr_addr | input | NUM_BUS*ADDR_W | Per-bus write address, bus i at bits [i*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_BUS*DATA_W | Per-bus write data, bus i at bits [i*DATA_W +: DATA_W] |
| rd_en | input | 1 | Read strobe; `rd_data` is 0 while low |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |

## Verification
Two collisions can happen in a single cycle, and the bench drives both through the two write buses at once.

The first is an operand load and a trigger firing together. The bench writes a fresh pattern on bus 0 and a matching trigger word on bus 1 while the stored pattern still differs. It judges the case by the result: a result of 1 shows the new pattern took part in the compare.

The second is two buses writing the same location. The bench reads the pattern back and expects the bus 1 value.

A third case fires a trigger during the busy cycle. The bench checks that busy persists for one more cycle and that the flag reflects the later word.

// File: rtl/tt_match_pkg.sv
package tt_match_pkg;

    // Word offsets of the unit's locations relative to its base address
    localparam int OFS_PATTERN = 0;
    localparam int OFS_MASK    = 1;
    localparam int OFS_TRIGGER = 2;
    localparam int OFS_RESULT  = 3;
    localparam int OFS_STATUS  = 4;

    // Status word bit positions
    localparam int STS_VALID_BIT = 0;
    localparam int STS_BUSY_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_HOLD = 2'd2
    } cmp_state_t;

endpackage

// File: rtl/tt_match_regs.sv
module tt_match_regs
    import tt_match_pkg::*;
#(
    parameter int NUM_BUS   = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BUS-1:0]         wr_en,
    input  logic [NUM_BUS*ADDR_W-1:0]  wr_addr,
    input  logic [NUM_BUS*DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]          pattern_q,
    output logic [DATA_W-1:0]          mask_q,
    output logic [DATA_W-1:0]          trig_q,
    output logic                       trig_hit
);

    localparam logic [ADDR_W-1:0] ADDR_PAT = ADDR_W'(BASE_ADDR + OFS_PATTERN);
    localparam logic [ADDR_W-1:0] ADDR_MSK = ADDR_W'(BASE_ADDR + OFS_MASK);
    localparam logic [ADDR_W-1:0] ADDR_TRG = ADDR_W'(BASE_ADDR + OFS_TRIGGER);

    logic [NUM_BUS-1:0] hit_pat;
    logic [NUM_BUS-1:0] hit_msk;
    logic [NUM_BUS-1:0] hit_trg;
    logic [DATA_W-1:0]  bus_data [NUM_BUS];

    // One address decoder per move bus
    generate
        for (genvar i = 0; i < NUM_BUS; i++) begin : g_bus
            logic [ADDR_W-1:0] bus_addr;
            assign bus_addr    = wr_addr[i*ADDR_W +: ADDR_W];
            assign bus_data[i] = wr_data[i*DATA_W +: DATA_W];
            assign hit_pat[i]  = wr_en[i] && (bus_addr == ADDR_PAT);
            assign hit_msk[i]  = wr_en[i] && (bus_addr == ADDR_MSK);
            assign hit_trg[i]  = wr_en[i] && (bus_addr == ADDR_TRG);
        end
    endgenerate

    logic [DATA_W-1:0] pat_nxt;
    logic [DATA_W-1:0] msk_nxt;
    logic [DATA_W-1:0] trg_nxt;

    // Ascending scan: the highest-numbered writing bus wins
    always_comb begin
        pat_nxt = pattern_q;
        msk_nxt = mask_q;
        trg_nxt = trig_q;
        for (int i = 0; i < NUM_BUS; i++) begin
            if (hit_pat[i]) pat_nxt = bus_data[i];
            if (hit_msk[i]) msk_nxt = bus_data[i];
            if (hit_trg[i]) trg_nxt = bus_data[i];
        end
    end

    assign trig_hit = |hit_trg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern_q <= '0;
            mask_q    <= '1;
            trig_q    <= '0;
        end else begin
            pattern_q <= pat_nxt;
            mask_q    <= msk_nxt;
            trig_q    <= trg_nxt;
        end
    end

    AST_OPERANDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> ($stable(pattern_q) && $stable(mask_q) && $stable(trig_q))); // R9

endmodule

// File: rtl/tt_match_core.sv
module tt_match_core
    import tt_match_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_hit,
    input  logic [DATA_W-1:0] trig_q,
    input  logic [DATA_W-1:0] pattern_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] result_q,
    output logic              valid,
    output logic              busy
);

    cmp_state_t state_q;
    cmp_state_t state_nxt;

    // Per-bit masked difference
    logic [DATA_W-1:0] diff;
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign diff[b] = mask_q[b] & (trig_q[b] ^ pattern_q[b]);
        end
    endgenerate

    logic is_match;
    assign is_match = ~|diff;

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (trig_hit) state_nxt = ST_EVAL;
            ST_EVAL: state_nxt = trig_hit ? ST_EVAL : ST_HOLD;
            ST_HOLD: if (trig_hit) state_nxt = ST_EVAL;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Result capture at the end of the compare cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (state_q == ST_EVAL) begin
            result_q <= DATA_W'(is_match);
        end
    end

    // Output decode
    always_comb begin
        valid = 1'b0;
        busy  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EVAL: busy  = 1'b1;
            ST_HOLD: valid = 1'b1;
            default: ;
        endcase
    end

    AST_EVAL_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !trig_hit) |=> valid); // R3

    AST_TRIGGER_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> (busy && !valid)); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result_q)); // R2

    AST_RESULT_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (result_q[DATA_W-1:1] == '0)); // R5

endmodule

// File: rtl/tt_match_rdmux.sv
module tt_match_rdmux
    import tt_match_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 64
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] pattern_q,
    input  logic [DATA_W-1:0] mask_q,
    input  logic [DATA_W-1:0] trig_q,
    input  logic [DATA_W-1:0] result_q,
    input  logic              valid,
    input  logic              busy,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] ADDR_PAT = ADDR_W'(BASE_ADDR + OFS_PATTERN);
    localparam logic [ADDR_W-1:0] ADDR_MSK = ADDR_W'(BASE_ADDR + OFS_MASK);
    localparam logic [ADDR_W-1:0] ADDR_TRG = ADDR_W'(BASE_ADDR + OFS_TRIGGER);
    localparam logic [ADDR_W-1:0] ADDR_RES = ADDR_W'(BASE_ADDR + OFS_RESULT);
    localparam logic [ADDR_W-1:0] ADDR_STS = ADDR_W'(BASE_ADDR + OFS_STATUS);

    logic [DATA_W-1:0] status_word;
    always_comb begin
        status_word = '0;
        status_word[STS_VALID_BIT] = valid;
        status_word[STS_BUSY_BIT]  = busy;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if      (rd_addr == ADDR_PAT) rd_data = pattern_q;
            else if (rd_addr == ADDR_MSK) rd_data = mask_q;
            else if (rd_addr == ADDR_TRG) rd_data = trig_q;
            else if (rd_addr == ADDR_RES) rd_data = result_q;
            else if (rd_addr == ADDR_STS) rd_data = status_word;
        end
    end

endmodule

// File: rtl/tt_match_unit.sv
module tt_match_unit
    import tt_match_pkg::*;
#(
    parameter int NUM_BUS   = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BUS-1:0]        wr_en,
    input  logic [NUM_BUS*ADDR_W-1:0] wr_addr,
    input  logic [NUM_BUS*DATA_W-1:0] wr_data,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data
);

    logic [DATA_W-1:0] pattern_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] trig_q;
    logic [DATA_W-1:0] result_q;
    logic              trig_hit;
    logic              valid;
    logic              busy;

    tt_match_regs #(
        .NUM_BUS   (NUM_BUS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pattern_q (pattern_q),
        .mask_q    (mask_q),
        .trig_q    (trig_q),
        .trig_hit  (trig_hit)
    );

    tt_match_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_hit  (trig_hit),
        .trig_q    (trig_q),
        .pattern_q (pattern_q),
        .mask_q    (mask_q),
        .result_q  (result_q),
        .valid     (valid),
        .busy      (busy)
    );

    tt_match_rdmux #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_rdmux (
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .pattern_q (pattern_q),
        .mask_q    (mask_q),
        .trig_q    (trig_q),
        .result_q  (result_q),
        .valid     (valid),
        .busy      (busy),
        .rd_data   (rd_data)
    );

    AST_NO_BUSY_AND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> !valid); // R6

endmodule

// File: tb/tt_match_unit_tb.sv
`timescale 1ns/1ps
module tt_match_unit_tb;

    localparam int NB = 2;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int BASE = 64;

    localparam logic [AW-1:0] A_PAT = 8'h40;
    localparam logic [AW-1:0] A_MSK = 8'h41;
    localparam logic [AW-1:0] A_TRG = 8'h42;
    localparam logic [AW-1:0] A_RES = 8'h43;
    localparam logic [AW-1:0] A_STS = 8'h44;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NB-1:0]      wr_en = '0;
    logic [NB*AW-1:0]   wr_addr = '0;
    logic [NB*DW-1:0]   wr_data = '0;
    logic               rd_en = 1'b0;
    logic [AW-1:0]      rd_addr = '0;
    logic [DW-1:0]      rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_exp  [$];
    string         q_tag  [$];

    always #2 clk = ~clk;

    tt_match_unit #(.NUM_BUS(NB), .DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Monitor: pops one expected item per read cycle
    always @(negedge clk) begin
        if (rd_en && q_exp.size() > 0) begin
            logic [DW-1:0] e;
            logic [AW-1:0] a;
            string t;
            e = q_exp.pop_front();
            a = q_addr.pop_front();
            t = q_tag.pop_front();
            n_cmp++;
            if (rd_data !== e) begin
                n_bad++;
                $display("FAIL %s: addr %h actual %h expected %h", t, a, rd_data, e);
            end
        end
    end

    function automatic logic [DW-1:0] model(input logic [DW-1:0] t, input logic [DW-1:0] p,
                                            input logic [DW-1:0] m);
        return (((t ^ p) & m) == '0) ? 32'h1 : 32'h0;
    endfunction

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        rd_en = 1'b1;
        rd_addr = a;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic wr1(input int bus, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en[bus] = 1'b1;
        wr_addr[bus*AW +: AW] = a;
        wr_data[bus*DW +: DW] = d;
        @(posedge clk);
        #1;
        wr_en = '0;
    endtask

    task automatic wr2(input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                       input logic [AW-1:0] a1, input logic [DW-1:0] d1);
        wr_en = 2'b11;
        wr_addr = {a1, a0};
        wr_data = {d1, d0};
        @(posedge clk);
        #1;
        wr_en = '0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 reset values and read-back map
        rd(A_PAT, 32'h0, "R1 pattern reset");
        rd(A_MSK, 32'hFFFF_FFFF, "R1 mask reset");
        rd(A_TRG, 32'h0, "R1 trigger reset");
        rd(A_RES, 32'h0, "R1 result reset");
        rd(A_STS, 32'h0, "R1 status reset");

        // R2 operand writes alone start nothing
        wr1(0, A_PAT, 32'hA5A5_0000);
        rd(A_STS, 32'h0, "R2 status after pattern write");
        wr1(1, A_MSK, 32'hFFFF_FFFF);
        rd(A_RES, 32'h0, "R2 result after mask write");
        rd(A_PAT, 32'hA5A5_0000, "R1 pattern read-back");

        // R3/R5 exact match
        wr1(0, A_TRG, 32'hA5A5_0000);
        rd(A_STS, 32'h2, "R3 busy in compare cycle");
        rd(A_STS, 32'h1, "R3 valid after compare");
        rd(A_RES, model(32'hA5A5_0000, 32'hA5A5_0000, 32'hFFFF_FFFF), "R5 match reads 1");

        // R6 valid clears on trigger, R5 mismatch reads 0
        wr1(1, A_TRG, 32'hA5A5_0001);
        rd(A_STS, 32'h2, "R6 valid cleared by trigger");
        rd(A_RES, 32'h0, "R5 mismatch reads 0");

        // R4 masked compare
        wr1(0, A_MSK, 32'hFFFF_0000);
        wr1(0, A_TRG, 32'hA5A5_1234);
        rd(A_STS, 32'h2, "R4 busy");
        rd(A_RES, model(32'hA5A5_1234, 32'hA5A5_0000, 32'hFFFF_0000), "R4 masked bits ignored");
        wr1(0, A_TRG, 32'hA5A4_1234);
        rd(A_STS, 32'h2, "R4 busy again");
        rd(A_RES, 32'h0, "R4 unmasked bit mismatch");
        wr1(1, A_MSK, 32'h0);
        wr1(1, A_TRG, 32'h1357_9BDF);
        rd(A_STS, 32'h2, "R4 busy zero mask");
        rd(A_RES, 32'h1, "R4 zero mask always matches");

        // R7 operand and trigger in the same cycle
        wr1(0, A_MSK, 32'hFFFF_FFFF);
        wr2(A_PAT, 32'h1111_1111, A_TRG, 32'h1111_1111);
        rd(A_STS, 32'h2, "R7 busy");
        rd(A_RES, 32'h1, "R7 new pattern used");

        // R8 same location from both buses: bus 1 wins
        wr2(A_PAT, 32'h0000_0002, A_PAT, 32'h0000_0003);
        rd(A_PAT, 32'h3, "R8 highest bus wins");
        rd(A_STS, 32'h1, "R2 status kept after operand write");

        // R10 retrigger during the compare cycle
        wr1(0, A_TRG, 32'h0000_0009);
        wr1(1, A_TRG, 32'h0000_0003);
        rd(A_STS, 32'h2, "R10 busy extended");
        rd(A_STS, 32'h1, "R10 valid after restart");
        rd(A_RES, 32'h1, "R10 result of later word");

        // R9 unmapped reads return 0 and leave state alone
        rd(8'h45, 32'h0, "R9 unmapped above window");
        rd(8'h00, 32'h0, "R9 unmapped low");
        rd(A_STS, 32'h1, "R9 status untouched by reads");
        rd(A_RES, 32'h1, "R9 result untouched by reads");

        @(posedge clk);
        #1;
        if (q_exp.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", q_exp.size());
        end
        done = 1'b1;
        summary();
    end

endmodule